// File: doc/BRIEF.md
# Contact Card Power-Up and Cold-Reset Sequencer

This block sits on the interface side of an asynchronous contact card slot. On a start request with a card present, it brings the contacts up one at a time, with a settle interval per step. The order is: reset held low, supply on, interface I/O to receive, programming supply to idle, card clock running. It then holds reset low for a fixed number of card clock cycles and watches the level-sampled I/O line for the falling edge that marks the start of the card's answer. If no answer comes, it raises reset and watches again for the same number of cycles.

An answer edge inside the permitted window ends the sequence in an "answer started" state with all contacts left up. Three conditions count as failures:
- an edge that arrives too early;
- a line that the card has not released high in time;
- silence through both windows.

Each failure tears the contacts down in the reverse order: reset low, clock stopped, programming supply off, I/O driven low, supply off. The block then parks in a timeout state. An abort or the loss of the card-present flag runs the same teardown but ends in idle. The card clock is the gated form of this block's clock, so every count below is in card clock cycles.

Top module: `card_activation_seq`

## Requirements
- R1: After reset, every contact output is 0 (reset low, supply off, programming supply off, clock gated off, I/O driven low with `ioRxMode`=0), both error flags are 0, and `status` is 0. The status codes are: 0 idle, 1 activating, 2 waiting with reset low, 3 waiting with reset high, 4 answer started, 5 timeout, 6 deactivating.
- R2: Activation starts only from status 0 or 5, only when `startReq` and `cardPresent` are 1 and `abortReq` is 0. Otherwise a start request leaves `status` and the contacts unchanged. A start request in status 4 is ignored.
- R3: Activation begins at edge E, which moves `status` to 1. With S = SETTLE_CYCLES, `vccEn` rises at E+S, `ioRxMode` at E+2S, `vppIdleEn` at E+3S and `cardClkEn` at E+4S. `status` becomes 2 at the same edge, E+4S. `cardRst` stays 0 throughout.
- R4: Let C be the edge that starts the clock, and W = ANSWER_WINDOW. With no answer, `cardRst` stays 0 through edge C+W-1, rises at C+W, and `status` becomes 3 at C+W.
- R5: In status 2 or 3, count the edges since the window start (C, or the edge that raised reset). An I/O falling edge seen while that count is between EARLIEST_ANSWER and W-1 inclusive moves `status` to 4 on the next edge. This holds even at count W-1. All contacts stay as they were.
- R6: An I/O falling edge seen while the count is below EARLIEST_ANSWER sets `earlyErr` and starts deactivation on the next edge. The sequence ends in status 5.
- R7: In status 2, if I/O is still low at count RELEASE_LIMIT-1, `releaseErr` is set and deactivation starts on the next edge. The sequence ends in status 5.
- R8: In status 3, if no falling edge arrives by count W-1, deactivation starts on the next edge. The sequence ends in status 5 with both error flags 0.
- R9: Deactivation begins at edge D, which sets `status` to 6 and `cardRst` to 0. `cardClkEn` falls at D+S, `vppIdleEn` at D+2S, `ioRxMode` at D+3S and `vccEn` at D+4S. At D+4S `status` takes its final value.
- R10: An abort or a low `cardPresent` in status 1, 2, 3 or 4 starts deactivation on the next edge, and the sequence ends in status 0. An abort in status 0 or 6 has no effect.
- R11: Both error flags clear at the edge that starts a new activation. Otherwise they hold their value, including through deactivation.
- R12: No more than one contact output changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the card clock is its gated form |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to power up and cold-reset the card |
| cardPresent | input | 1 | Card is seated in the slot |
| abortReq | input | 1 | Request to tear the session down |
| ioIn | input | 1 | Sampled level of the card I/O line |
| cardRst | output | 1 | Card reset contact level |
| vccEn | output | 1 | Card supply enable |
| vppIdleEn | output | 1 | Programming supply held at its idle level |
| cardClkEn | output | 1 | Card clock gate enable |
| ioRxMode | output | 1 | 1: interface I/O receives; 0: I/O driven low |
| status | output | 3 | Sequencer state code (see R1) |
| earlyErr | output | 1 | An answer edge arrived before the earliest count |
| releaseErr | output | 1 | The card did not release I/O high in time |

## Verification
Every outcome lands exactly one edge after the cycle that decided it, and the bench computes that edge from the settle interval and window counts. Contact and status outcomes are checked at that edge. An answer edge driven at window count k is judged at edge C+k+1. A reset rise is due at C+W, and each teardown step is due S edges after the previous one. The bench drives and samples on the falling clock edge and tracks the count of edges since each reference point. It checks every cycle of activation and deactivation against the stage arithmetic. It sweeps the answer offset k over every count of both windows, so the boundaries at EARLIEST_ANSWER-1, EARLIEST_ANSWER and W-1 are all compared.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // contact index order is the power-up order; power-down walks it backwards
  localparam int NUM_CONTACTS = 4;  // 0 supply, 1 rx mode, 2 prog idle, 3 clock
  localparam int STEP_W       = $clog2(NUM_CONTACTS);

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ACTIVATING = 3'd1,
    ST_WAIT_LOW   = 3'd2,
    ST_WAIT_HIGH  = 3'd3,
    ST_ANSWERED   = 3'd4,
    ST_TIMEOUT    = 3'd5,
    ST_DEACT      = 3'd6
  } seqState_t;

  typedef struct packed {
    logic                    settleClr;
    logic                    winClr;
    logic [NUM_CONTACTS-1:0] onMask;
    logic [NUM_CONTACTS-1:0] offMask;
    logic                    rstHigh;
    logic                    rstLow;
    logic                    earlySet;
    logic                    relSet;
    logic                    errClr;
  } seqCmd_t;

  typedef struct packed {
    logic settleDone;
    logic ioFall;
    logic ioLow;
    logic earlyZone;
    logic releaseDue;
    logic windowEnd;
  } seqFlags_t;
endpackage

// File: rtl/cardseq_dp.sv
module cardseq_dp
  import cardseq_pkg::*;
#(
  parameter int SETTLE_CYCLES   = 4,
  parameter int ANSWER_WINDOW   = 40000,
  parameter int EARLIEST_ANSWER = 400,
  parameter int RELEASE_LIMIT   = 200
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqCmd_t                 cmd,
  input  logic                    ioIn,
  output seqFlags_t               flags,
  output logic [NUM_CONTACTS-1:0] contactQ,
  output logic                    rstQ,
  output logic                    earlyErr,
  output logic                    releaseErr
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int WW = $clog2(ANSWER_WINDOW + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);
  localparam logic [WW-1:0] WIN_LAST    = WW'(ANSWER_WINDOW - 1);
  localparam logic [WW-1:0] WIN_SAT     = WW'(ANSWER_WINDOW);
  localparam logic [WW-1:0] EARLY_LIM   = WW'(EARLIEST_ANSWER);
  localparam logic [WW-1:0] REL_LAST    = WW'(RELEASE_LIMIT - 1);

  logic [SW-1:0] settleCnt;
  logic [WW-1:0] winCnt;
  logic          ioPrev;

  // settle pacing: free-running wrap, restarted on each sequence entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       settleCnt <= '0;
    else if (cmd.settleClr)          settleCnt <= '0;
    else if (settleCnt == SETTLE_LAST) settleCnt <= '0;
    else                             settleCnt <= settleCnt + 1'b1;
  end

  // answer window: card clock cycles since the current time reference
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 winCnt <= '0;
    else if (cmd.winClr)       winCnt <= '0;
    else if (winCnt != WIN_SAT) winCnt <= winCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ioPrev <= 1'b0;
    else       ioPrev <= ioIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contactQ <= '0;
      rstQ     <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CONTACTS; i++) begin
        if (cmd.offMask[i])     contactQ[i] <= 1'b0;
        else if (cmd.onMask[i]) contactQ[i] <= 1'b1;
      end
      if (cmd.rstLow)       rstQ <= 1'b0;
      else if (cmd.rstHigh) rstQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      earlyErr   <= 1'b0;
      releaseErr <= 1'b0;
    end else if (cmd.errClr) begin
      earlyErr   <= 1'b0;
      releaseErr <= 1'b0;
    end else begin
      if (cmd.earlySet) earlyErr   <= 1'b1;
      if (cmd.relSet)   releaseErr <= 1'b1;
    end
  end

  always_comb begin
    flags.settleDone = (settleCnt == SETTLE_LAST);
    flags.ioFall     = ioPrev & ~ioIn;
    flags.ioLow      = ~ioIn;
    flags.earlyZone  = (winCnt < EARLY_LIM);
    flags.releaseDue = (winCnt == REL_LAST);
    flags.windowEnd  = (winCnt == WIN_LAST);
  end

  // a contact may only move at the end of a settle interval
  for (genvar i = 0; i < NUM_CONTACTS; i++) begin : g_contactChecks
    p_settle_paced_r3: assert property (@(posedge clk) disable iff (!rstN)
      (contactQ[i] != $past(contactQ[i])) |-> ($past(settleCnt) == SETTLE_LAST));
    if (i > 0) begin : g_order
      // a later contact is never up without every earlier one
      p_supply_order_r9: assert property (@(posedge clk) disable iff (!rstN)
        contactQ[i] |-> contactQ[i-1]);
    end
  end

  p_rst_needs_clock_r4: assert property (@(posedge clk) disable iff (!rstN)
    rstQ |-> contactQ[NUM_CONTACTS-1]);

  p_one_change_r12: assert property (@(posedge clk) disable iff (!rstN)
    $countones({contactQ, rstQ} ^ $past({contactQ, rstQ})) <= 1);
endmodule

// File: rtl/cardseq_ctrl.sv
module cardseq_ctrl
  import cardseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      cardPresent,
  input  logic      abortReq,
  input  seqFlags_t flags,
  output seqCmd_t   cmd,
  output seqState_t state
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_CONTACTS - 1);

  seqState_t         stateNext;
  logic [STEP_W-1:0] step, stepNext;
  logic              failEnd, failNext;
  logic              deactReq, deactFail, lossOfCard;

  always_comb begin
    cmd        = '0;
    stateNext  = state;
    stepNext   = step;
    failNext   = failEnd;
    deactReq   = 1'b0;
    deactFail  = 1'b0;
    lossOfCard = abortReq | ~cardPresent;

    unique case (state)
      ST_IDLE, ST_TIMEOUT: begin
        if (startReq && cardPresent && !abortReq) begin
          stateNext     = ST_ACTIVATING;
          stepNext      = '0;
          cmd.settleClr = 1'b1;
          cmd.errClr    = 1'b1;
        end
      end
      ST_ACTIVATING: begin
        if (lossOfCard) begin
          deactReq = 1'b1;
        end else if (flags.settleDone) begin
          cmd.onMask = NUM_CONTACTS'(1) << step;
          stepNext   = step + 1'b1;
          if (step == LAST_STEP) begin
            stateNext  = ST_WAIT_LOW;
            cmd.winClr = 1'b1;
          end
        end
      end
      ST_WAIT_LOW: begin
        if (lossOfCard) begin
          deactReq = 1'b1;
        end else if (flags.ioFall) begin
          if (flags.earlyZone) begin
            cmd.earlySet = 1'b1;
            deactReq     = 1'b1;
            deactFail    = 1'b1;
          end else begin
            stateNext = ST_ANSWERED;
          end
        end else if (flags.releaseDue && flags.ioLow) begin
          cmd.relSet = 1'b1;
          deactReq   = 1'b1;
          deactFail  = 1'b1;
        end else if (flags.windowEnd) begin
          cmd.rstHigh = 1'b1;
          cmd.winClr  = 1'b1;
          stateNext   = ST_WAIT_HIGH;
        end
      end
      ST_WAIT_HIGH: begin
        if (lossOfCard) begin
          deactReq = 1'b1;
        end else if (flags.ioFall) begin
          if (flags.earlyZone) begin
            cmd.earlySet = 1'b1;
            deactReq     = 1'b1;
            deactFail    = 1'b1;
          end else begin
            stateNext = ST_ANSWERED;
          end
        end else if (flags.windowEnd) begin
          deactReq  = 1'b1;
          deactFail = 1'b1;
        end
      end
      ST_ANSWERED: begin
        if (lossOfCard) deactReq = 1'b1;
      end
      ST_DEACT: begin
        if (flags.settleDone) begin
          cmd.offMask = NUM_CONTACTS'(1) << (LAST_STEP - step);
          stepNext    = step + 1'b1;
          if (step == LAST_STEP) stateNext = failEnd ? ST_TIMEOUT : ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase

    if (deactReq) begin
      stateNext     = ST_DEACT;
      stepNext      = '0;
      failNext      = deactFail;
      cmd.settleClr = 1'b1;
      cmd.rstLow    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      step    <= '0;
      failEnd <= 1'b0;
    end else begin
      state   <= stateNext;
      step    <= stepNext;
      failEnd <= failNext;
    end
  end

  p_loss_deacts_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ACTIVATING || state == ST_WAIT_LOW || state == ST_WAIT_HIGH ||
      state == ST_ANSWERED) && (abortReq || !cardPresent)) |=> (state == ST_DEACT));

  p_deact_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEACT && !flags.settleDone) |=> (state == ST_DEACT));

  p_answer_not_early_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ANSWERED && $past(state) != ST_ANSWERED) |-> $past(!flags.earlyZone));
endmodule

// File: rtl/card_activation_seq.sv
module card_activation_seq
  import cardseq_pkg::*;
#(
  parameter int SETTLE_CYCLES   = 4,
  parameter int ANSWER_WINDOW   = 40000,
  parameter int EARLIEST_ANSWER = 400,
  parameter int RELEASE_LIMIT   = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       cardPresent,
  input  logic       abortReq,
  input  logic       ioIn,
  output logic       cardRst,
  output logic       vccEn,
  output logic       vppIdleEn,
  output logic       cardClkEn,
  output logic       ioRxMode,
  output logic [2:0] status,
  output logic       earlyErr,
  output logic       releaseErr
);
  timeunit 1ns;
  timeprecision 1ps;

  seqCmd_t                 cmd;
  seqFlags_t               flags;
  seqState_t               state;
  logic [NUM_CONTACTS-1:0] contactQ;

  cardseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .cardPresent(cardPresent),
    .abortReq   (abortReq),
    .flags      (flags),
    .cmd        (cmd),
    .state      (state)
  );

  cardseq_dp #(
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .ANSWER_WINDOW  (ANSWER_WINDOW),
    .EARLIEST_ANSWER(EARLIEST_ANSWER),
    .RELEASE_LIMIT  (RELEASE_LIMIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .ioIn      (ioIn),
    .flags     (flags),
    .contactQ  (contactQ),
    .rstQ      (cardRst),
    .earlyErr  (earlyErr),
    .releaseErr(releaseErr)
  );

  assign vccEn     = contactQ[0];
  assign ioRxMode  = contactQ[1];
  assign vppIdleEn = contactQ[2];
  assign cardClkEn = contactQ[3];
  assign status    = state;

  p_rest_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_IDLE || status == ST_TIMEOUT) |->
      !(vccEn || ioRxMode || vppIdleEn || cardClkEn || cardRst));

  p_wait_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_WAIT_LOW) |-> (cardClkEn && !cardRst));

  p_wait_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_WAIT_HIGH) |-> (cardClkEn && cardRst));
endmodule

// File: tb/test_card_activation_seq.sv
module test_card_activation_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int S    = 2;
  localparam int W    = 40;
  localparam int MINA = 10;
  localparam int REL  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, cardPresent = 1'b0, abortReq = 1'b0, ioIn = 1'b0;
  logic cardRst, vccEn, vppIdleEn, cardClkEn, ioRxMode, earlyErr, releaseErr;
  logic [2:0] status;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  card_activation_seq #(
    .SETTLE_CYCLES(S), .ANSWER_WINDOW(W), .EARLIEST_ANSWER(MINA), .RELEASE_LIMIT(REL)
  ) i_card_activation_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cardPresent(cardPresent),
    .abortReq(abortReq), .ioIn(ioIn), .cardRst(cardRst), .vccEn(vccEn),
    .vppIdleEn(vppIdleEn), .cardClkEn(cardClkEn), .ioRxMode(ioRxMode),
    .status(status), .earlyErr(earlyErr), .releaseErr(releaseErr)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {rst, clk, prog idle, rx, supply}
  function automatic int cvec();
    return int'({cardRst, cardClkEn, vppIdleEn, ioRxMode, vccEn});
  endfunction

  function automatic int mk(bit r, bit c, bit p, bit x, bit v);
    return int'({r, c, p, x, v});
  endfunction

  // leaves the bench at the negedge right after the clock-start edge (count 0)
  task automatic doActivate(bit ioStart);
    int prev;
    ioIn = ioStart;
    startReq = 1'b1; cardPresent = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R11 early flag cleared", int'(earlyErr), 0);
    check("R11 release flag cleared", int'(releaseErr), 0);
    prev = cvec();
    for (int t = 0; t <= 4 * S; t++) begin
      if (t > 0) @(negedge clk);
      check("R3 contacts", cvec(),
            mk(1'b0, t >= 4 * S, t >= 3 * S, t >= 2 * S, t >= S));
      check("R3 status", int'(status), (t < 4 * S) ? 1 : 2);
      check("R12 single change", int'($countones(prev ^ cvec()) <= 1), 1);
      prev = cvec();
    end
  endtask

  // call at the negedge right after the deactivation entry edge
  task automatic deactCheck(logic [3:0] initOn, int endStatus);
    int prev = cvec();
    for (int d = 0; d <= 4 * S; d++) begin
      if (d > 0) @(negedge clk);
      check("R9 contacts", cvec(),
            mk(1'b0, initOn[3] && d < S, initOn[2] && d < 2 * S,
               initOn[1] && d < 3 * S, initOn[0] && d < 4 * S));
      check("R9 status", int'(status), (d < 4 * S) ? 6 : endStatus);
      check("R12 single change", int'($countones(prev ^ cvec()) <= 1), 1);
      prev = cvec();
    end
  endtask

  task automatic judgeAnswer(int k, bit highPhase);
    if (k < MINA) begin
      check("R6 early status", int'(status), 6);
      check("R6 early flag", int'(earlyErr), 1);
      deactCheck(4'hF, 5);
      check("R11 early flag held", int'(earlyErr), 1);
    end else begin
      check("R5 answer status", int'(status), 4);
      check("R5 contacts held", cvec(), mk(highPhase, 1, 1, 1, 1));
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      check("R2 start ignored in answer", int'(status), 4);
      if (highPhase) cardPresent = 1'b0; else abortReq = 1'b1;
      @(negedge clk);
      abortReq = 1'b0; cardPresent = 1'b1;
      deactCheck(4'hF, 0);
    end
  endtask

  task automatic runLow(int k);
    doActivate(1'b1);
    for (int j = 0; j < k; j++) @(negedge clk);
    ioIn = 1'b0;
    @(negedge clk);
    judgeAnswer(k, 1'b0);
  endtask

  task automatic runHigh(int k);
    doActivate(1'b1);
    for (int j = 0; j < W - 1; j++) @(negedge clk);
    check("R4 reset still low", int'(cardRst), 0);
    check("R4 status low wait", int'(status), 2);
    @(negedge clk);
    check("R4 reset raised", int'(cardRst), 1);
    check("R4 status high wait", int'(status), 3);
    if (k < 0) begin
      for (int j = 0; j < W - 1; j++) @(negedge clk);
      check("R8 still waiting", int'(status), 3);
      @(negedge clk);
      check("R8 timeout deact", int'(status), 6);
      deactCheck(4'hF, 5);
      check("R8 no early flag", int'(earlyErr), 0);
      check("R8 no release flag", int'(releaseErr), 0);
    end else begin
      for (int j = 0; j < k; j++) @(negedge clk);
      ioIn = 1'b0;
      @(negedge clk);
      judgeAnswer(k, 1'b1);
    end
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 contacts", cvec(), 0);
    check("R1 status", int'(status), 0);
    check("R1 flags", int'({earlyErr, releaseErr}), 0);

    // start without a card, start with abort, abort alone: all ignored
    startReq = 1'b1; cardPresent = 1'b0;
    @(negedge clk);
    check("R2 no card", int'(status), 0);
    cardPresent = 1'b1; abortReq = 1'b1;
    @(negedge clk);
    check("R2 start with abort", int'(status), 0);
    startReq = 1'b0;
    @(negedge clk);
    abortReq = 1'b0;
    check("R10 abort in idle", int'(status), 0);
    check("R10 abort in idle contacts", cvec(), 0);

    // abort partway through power-up: only the supply was up
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (S) @(negedge clk);
    check("R3 supply up", cvec(), mk(0, 0, 0, 0, 1));
    abortReq = 1'b1;
    @(negedge clk);
    check("R10 abort in activation", int'(status), 6);
    deactCheck(4'b0001, 0);
    abortReq = 1'b0;

    // I/O never released
    doActivate(1'b0);
    for (int j = 0; j < REL - 1; j++) @(negedge clk);
    check("R7 before limit", int'(status), 2);
    @(negedge clk);
    check("R7 deact", int'(status), 6);
    check("R7 release flag", int'(releaseErr), 1);
    check("R7 early flag", int'(earlyErr), 0);
    deactCheck(4'hF, 5);

    // restart from timeout, then no answer anywhere
    runHigh(-1);

    for (int k = 0; k < W; k++) runLow(k);
    for (int k = 0; k < W; k++) runHigh(k);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule